// File: doc/BRIEF.md
# Programmed-I/O FIFO Transfer Port

This block lets a host move bytes between its register bus and a local byte-wide packet buffer without a bus-mastering engine. Before a transfer, the host writes a 16-bit buffer address as two bytes, one for the low half and one for the high half. It then writes the control register with the go bit and the direction bit set. From that point a small byte FIFO sits between the host's data port and the buffer. The block's own engine does two things, one byte per clock: it prefetches buffer bytes into the FIFO for host reads, and it drains FIFO bytes into the buffer for host writes. The buffer address advances by one for each byte the engine moves.

The host polls a ready flag in the status register and then moves a whole FIFO-sized group through the data port. It can use 16-bit word accesses, byte accesses, or a mix. A trailing partial group is normally moved with byte accesses. The host ends a transfer by writing the control register with the go bit clear. Sticky flags record misuse of the data port and the address wrapping past the end of the buffer. The buffer occupies a window of card addresses that starts at `BASE`.

Top module: `pio_fifo_port`

## Requirements
- R1: After reset, the control register, the status register and both address bytes read as 0x00.
- R2: Writing control with bit 7 (go) set while go is clear starts a transfer. This write empties the FIFO, clears status bits 6, 5 and 4, and latches control bit 6 as the direction: 1 means host to buffer, 0 means buffer to host. The latched direction holds until the next start, even if control is rewritten in between.
- R3: In the buffer-to-host direction, status bit 7 (ready) is 1 exactly when the FIFO holds DEPTH prefetched bytes. Bytes are delivered in buffer order, beginning at the loaded address.
- R4: A byte access on the data port (register 4) moves one byte on bits 7:0. A word access moves two bytes: bits 15:8 carry the byte at the lower buffer address, and bits 7:0 carry the next one.
- R5: A data-port read that asks for more bytes than the FIFO holds sets status bit 6 (underflow). That read returns 0 and consumes nothing.
- R6: In the host-to-buffer direction, ready is 1 while go is set and the FIFO is empty. Written bytes land at consecutive buffer addresses, starting at the loaded address.
- R7: A data-port write that would take the FIFO past DEPTH bytes, or that arrives while no host-to-buffer transfer is running, sets status bit 5 (overflow). The written data is discarded.
- R8: When the engine moves the byte at the last card address of the window (BASE + RAM_BYTES − 1), the address returns to BASE and status bit 4 (terminal count) is set.
- R9: Registers 2 and 3 read back the current address. Writes to them take effect only while status bit 3 (busy) is 0.
- R10: When go is cleared during a host-to-buffer transfer, the bytes still in the FIFO are written to the buffer, and busy stays 1 until the FIFO is empty. When go is cleared during a buffer-to-host transfer, the FIFO is discarded and busy drops at once.
- R11: A card address selects buffer byte (address mod RAM_BYTES). BASE is a multiple of RAM_BYTES, so an address above the window aliases onto it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Register access strobe, one access per cycle |
| bus_wr | input | 1 | 1 = write access, 0 = read access |
| bus_word | input | 1 | 1 = 16-bit data-port access, 0 = byte access |
| bus_addr | input | 3 | Register select: 0 control, 1 status, 2 address low, 3 address high, 4 data |
| bus_wdata | input | 16 | Write data; registers other than data use bits 7:0 |
| bus_rdata | output | 16 | Read data, valid in the cycle of a read access |

## Verification
The assertions take for granted that the host issues at most one register access per cycle, and that it loads the address only between transfers. Beyond that, they assume the direction does not change while the FIFO still holds bytes from the previous transfer. Each bench scenario therefore waits for busy to read 0 before it loads an address or starts a new transfer, and every access is driven by a one-cycle task. The two back-to-back word bursts are the one place where the stimulus deliberately pushes the FIFO to its limits: the overflow burst fills it past DEPTH, and the drain-after-stop burst stops the transfer with bytes still queued.

// File: rtl/pio_pkg.sv
package pio_pkg;
   typedef enum logic [2:0] {
      REG_CTRL = 3'd0,
      REG_STAT = 3'd1,
      REG_ADLO = 3'd2,
      REG_ADHI = 3'd3,
      REG_DATA = 3'd4
   } reg_sel_e;

   localparam int CTRL_GO     = 7;
   localparam int CTRL_TOCARD = 6;

   localparam int ST_READY = 7;
   localparam int ST_UNF   = 6;
   localparam int ST_OVF   = 5;
   localparam int ST_TC    = 4;
   localparam int ST_BUSY  = 3;
endpackage

// File: rtl/pio_byte_fifo.sv
module pio_byte_fifo #(
   parameter int DEPTH = 8,
   localparam int PW = $clog2(DEPTH),
   localparam int CW = $clog2(DEPTH + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          flush,
   input  logic [1:0]    push_n,
   input  logic [15:0]   push_data,
   input  logic [1:0]    pop_n,
   output logic [15:0]   peek,
   output logic [CW-1:0] count
);
   if (DEPTH < 4 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
      $error("pio_byte_fifo: DEPTH must be a power of two, at least 4");
   end

   logic [7:0]    mem [DEPTH];
   logic [PW-1:0] wptr, rptr;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wptr  <= '0;
         rptr  <= '0;
         count <= '0;
      end else if (flush) begin
         wptr  <= '0;
         rptr  <= '0;
         count <= '0;
      end else begin
         wptr  <= wptr + PW'(push_n);
         rptr  <= rptr + PW'(pop_n);
         count <= count + CW'(push_n) - CW'(pop_n);
      end
   end

   // lane 0 is the earlier byte, carried on bits 15:8
   always_ff @(posedge clk) begin
      if (!flush) begin
         for (int k = 0; k < 2; k++) begin
            if (push_n > 2'(k))
               mem[wptr + PW'(k)] <= push_data[15 - 8*k -: 8];
         end
      end
   end

   for (genvar i = 0; i < 2; i++) begin : g_peek
      assign peek[15 - 8*i -: 8] = mem[rptr + PW'(i)];
   end
endmodule

// File: rtl/pio_buffer_ram.sv
module pio_buffer_ram #(
   parameter int BYTES = 2048,
   localparam int AW = $clog2(BYTES)
) (
   input  logic          clk,
   input  logic          we,
   input  logic [AW-1:0] addr,
   input  logic [7:0]    wdata,
   output logic [7:0]    rdata
);
   if (BYTES < 16 || (BYTES & (BYTES - 1)) != 0) begin : g_bad_size
      $error("pio_buffer_ram: BYTES must be a power of two, at least 16");
   end

   logic [7:0] mem [BYTES];

   always_ff @(posedge clk) begin
      if (we) mem[addr] <= wdata;
   end

   assign rdata = mem[addr];
endmodule

// File: rtl/pio_addr_ptr.sv
module pio_addr_ptr #(
   parameter logic [15:0] BASE  = 16'h2000,
   parameter int          BYTES = 2048
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        ld_lo,
   input  logic        ld_hi,
   input  logic [7:0]  ld_byte,
   input  logic        step,
   output logic [15:0] ptr,
   output logic        wrap
);
   localparam logic [15:0] LAST = BASE + 16'(BYTES - 1);

   if ((int'(BASE) % BYTES) != 0) begin : g_bad_base
      $error("pio_addr_ptr: BASE must be aligned to BYTES");
   end

   assign wrap = step && (ptr == LAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      ptr       <= '0;
      else if (ld_lo)  ptr[7:0]  <= ld_byte;
      else if (ld_hi)  ptr[15:8] <= ld_byte;
      else if (step)   ptr       <= wrap ? BASE : ptr + 16'd1;
   end
endmodule

// File: rtl/pio_fifo_port.sv
module pio_fifo_port import pio_pkg::*; #(
   parameter int          DEPTH     = 8,
   parameter int          RAM_BYTES = 2048,
   parameter logic [15:0] BASE      = 16'h2000
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        bus_sel,
   input  logic        bus_wr,
   input  logic        bus_word,
   input  logic [2:0]  bus_addr,
   input  logic [15:0] bus_wdata,
   output logic [15:0] bus_rdata
);
   localparam int AW = $clog2(RAM_BYTES);
   localparam int CW = $clog2(DEPTH + 1);

   logic [7:0]    ctrl_q;
   logic          dir_q, tc_q, ovf_q, unf_q;
   logic          start, busy, ready;
   logic          acc_wr, acc_rd, is_data, is_ctrl;
   logic [1:0]    acc_n, push_n, pop_n;
   logic          rd_ok, wr_ok, wr_room;
   logic          start_rise, stop_req, flush;
   logic          eng_fill, eng_drain, addr_ld, wrap;
   logic [CW-1:0] fifo_cnt;
   logic [15:0]   peek, push_data, ptr;
   logic [7:0]    ram_q, status;

   assign acc_wr  = bus_sel && bus_wr;
   assign acc_rd  = bus_sel && !bus_wr;
   assign is_data = (bus_addr == REG_DATA);
   assign is_ctrl = (bus_addr == REG_CTRL);
   assign acc_n   = bus_word ? 2'd2 : 2'd1;
   assign start   = ctrl_q[CTRL_GO];

   assign start_rise = acc_wr && is_ctrl && bus_wdata[CTRL_GO] && !start;
   assign stop_req   = acc_wr && is_ctrl && !bus_wdata[CTRL_GO] && start;
   assign flush      = start_rise || (stop_req && !dir_q);

   assign busy  = dir_q ? (start || fifo_cnt != '0) : start;
   assign ready = start && (dir_q ? (fifo_cnt == '0) : (fifo_cnt == CW'(DEPTH)));

   assign rd_ok   = acc_rd && is_data && start && !dir_q && (fifo_cnt >= CW'(acc_n));
   assign wr_room = ({1'b0, fifo_cnt} + (CW+1)'(acc_n)) <= (CW+1)'(DEPTH);
   assign wr_ok   = acc_wr && is_data && start && dir_q && wr_room;

   assign eng_fill  = start && !dir_q && (fifo_cnt < CW'(DEPTH)) && !flush;
   assign eng_drain = dir_q && (fifo_cnt != '0) && !flush;

   assign push_n    = dir_q ? (wr_ok ? acc_n : 2'd0) : {1'b0, eng_fill};
   assign pop_n     = dir_q ? {1'b0, eng_drain} : (rd_ok ? acc_n : 2'd0);
   assign push_data = !dir_q   ? {ram_q, 8'h00} :
                      bus_word ? bus_wdata : {bus_wdata[7:0], 8'h00};

   assign addr_ld = acc_wr && !busy && (bus_addr == REG_ADLO || bus_addr == REG_ADHI);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q <= '0;
         dir_q  <= 1'b0;
      end else if (acc_wr && is_ctrl) begin
         ctrl_q <= bus_wdata[7:0];
         if (start_rise) dir_q <= bus_wdata[CTRL_TOCARD];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tc_q  <= 1'b0;
         ovf_q <= 1'b0;
         unf_q <= 1'b0;
      end else if (start_rise) begin
         tc_q  <= 1'b0;
         ovf_q <= 1'b0;
         unf_q <= 1'b0;
      end else begin
         if (wrap)                            tc_q  <= 1'b1;
         if (acc_wr && is_data && !wr_ok)     ovf_q <= 1'b1;
         if (acc_rd && is_data && !rd_ok)     unf_q <= 1'b1;
      end
   end

   always_comb begin
      status           = '0;
      status[ST_READY] = ready;
      status[ST_UNF]   = unf_q;
      status[ST_OVF]   = ovf_q;
      status[ST_TC]    = tc_q;
      status[ST_BUSY]  = busy;
   end

   always_comb begin
      bus_rdata = '0;
      if (acc_rd) begin
         case (reg_sel_e'(bus_addr))
            REG_CTRL: bus_rdata = {8'h00, ctrl_q};
            REG_STAT: bus_rdata = {8'h00, status};
            REG_ADLO: bus_rdata = {8'h00, ptr[7:0]};
            REG_ADHI: bus_rdata = {8'h00, ptr[15:8]};
            REG_DATA: if (rd_ok) bus_rdata = bus_word ? peek : {8'h00, peek[15:8]};
            default:  bus_rdata = '0;
         endcase
      end
   end

   pio_byte_fifo #(.DEPTH(DEPTH)) u_fifo (
      .clk       (clk),
      .rst_n     (rst_n),
      .flush     (flush),
      .push_n    (push_n),
      .push_data (push_data),
      .pop_n     (pop_n),
      .peek      (peek),
      .count     (fifo_cnt)
   );

   pio_addr_ptr #(.BASE(BASE), .BYTES(RAM_BYTES)) u_ptr (
      .clk     (clk),
      .rst_n   (rst_n),
      .ld_lo   (addr_ld && bus_addr == REG_ADLO),
      .ld_hi   (addr_ld && bus_addr == REG_ADHI),
      .ld_byte (bus_wdata[7:0]),
      .step    (eng_fill || eng_drain),
      .ptr     (ptr),
      .wrap    (wrap)
   );

   pio_buffer_ram #(.BYTES(RAM_BYTES)) u_ram (
      .clk   (clk),
      .we    (eng_drain),
      .addr  (ptr[AW-1:0]),
      .wdata (peek[15:8]),
      .rdata (ram_q)
   );
endmodule

// File: rtl/pio_fifo_port_chk.sv
module pio_fifo_port_chk #(
   parameter int          DEPTH = 8,
   parameter logic [15:0] BASE  = 16'h2000,
   localparam int CW = $clog2(DEPTH + 1)
) (
   input logic          clk,
   input logic          rst_n,
   input logic          start,
   input logic          dir_q,
   input logic          ready,
   input logic          busy,
   input logic [CW-1:0] count,
   input logic [15:0]   ptr,
   input logic          tc_flag,
   input logic          unf_flag,
   input logic          addr_ld,
   input logic          start_rise
);
   a_r3_ready_full: assert property (@(posedge clk) disable iff (!rst_n)
      ready && !dir_q |-> start && count == CW'(DEPTH));

   a_r6_ready_empty: assert property (@(posedge clk) disable iff (!rst_n)
      ready && dir_q |-> count == '0);

   a_r7_no_overfill: assert property (@(posedge clk) disable iff (!rst_n)
      count <= CW'(DEPTH));

   a_r8_tc_wrap: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(tc_flag) |-> ptr == BASE);

   a_r9_ptr_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !busy && !addr_ld |=> $stable(ptr));

   a_r5_unf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      unf_flag && !start_rise |=> unf_flag);

   a_r10_busy_drain: assert property (@(posedge clk) disable iff (!rst_n)
      dir_q && count != '0 |-> busy);
endmodule

bind pio_fifo_port pio_fifo_port_chk #(.DEPTH(DEPTH), .BASE(BASE)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .start      (start),
   .dir_q      (dir_q),
   .ready      (ready),
   .busy       (busy),
   .count      (fifo_cnt),
   .ptr        (ptr),
   .tc_flag    (tc_q),
   .unf_flag   (unf_q),
   .addr_ld    (addr_ld),
   .start_rise (start_rise)
);

// File: tb/sim_pio_fifo_port.sv
module sim_pio_fifo_port;
   localparam logic [2:0] A_CTRL = 3'd0, A_STAT = 3'd1, A_ADLO = 3'd2,
                          A_ADHI = 3'd3, A_DATA = 3'd4;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_sel = 1'b0, bus_wr = 1'b0, bus_word = 1'b0;
   logic [2:0]  bus_addr = '0;
   logic [15:0] bus_wdata = '0;
   logic [15:0] bus_rdata;
   int          n_checks = 0, n_errors = 0;
   logic        done = 1'b0;

   always #4 clk = ~clk;

   pio_fifo_port u0 (
      .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
      .bus_word(bus_word), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
      .bus_rdata(bus_rdata)
   );

   task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_errors++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic wreg(input logic [2:0] a, input logic w, input logic [15:0] d);
      @(negedge clk);
      bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_word = w; bus_wdata = d;
      @(posedge clk); #1;
      bus_sel = 1'b0; bus_wr = 1'b0;
   endtask

   task automatic rreg(input logic [2:0] a, input logic w, output logic [15:0] d);
      @(negedge clk);
      bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a; bus_word = w;
      #2 d = bus_rdata;
      @(posedge clk); #1;
      bus_sel = 1'b0;
   endtask

   task automatic set_addr(input logic [15:0] a);
      wreg(A_ADLO, 1'b0, {8'h00, a[7:0]});
      wreg(A_ADHI, 1'b0, {8'h00, a[15:8]});
   endtask

   task automatic wait_bit(input int b, input logic v, input string tag);
      logic [15:0] s;
      for (int i = 0; i < 200; i++) begin
         rreg(A_STAT, 1'b0, s);
         if (s[b] == v) return;
      end
      chk(tag, {15'b0, s[b]}, {15'b0, v});
   endtask

   task automatic t_reset();
      logic [15:0] d;
      rreg(A_STAT, 1'b0, d); chk("R1 status", d, 16'h0000);
      rreg(A_CTRL, 1'b0, d); chk("R1 ctrl", d, 16'h0000);
      rreg(A_ADLO, 1'b0, d); chk("R1 addr lo", d, 16'h0000);
      rreg(A_ADHI, 1'b0, d); chk("R1 addr hi", d, 16'h0000);
   endtask

   task automatic t_write_group();
      logic [15:0] d;
      set_addr(16'h2010);
      wreg(A_CTRL, 1'b0, 16'h00C0);
      wait_bit(7, 1'b1, "R6 ready when empty");
      wreg(A_DATA, 1'b1, 16'h1122);
      wreg(A_DATA, 1'b1, 16'h3344);
      wreg(A_DATA, 1'b1, 16'h5566);
      wreg(A_DATA, 1'b1, 16'h7788);
      wait_bit(7, 1'b1, "R6 ready after group");
      wreg(A_DATA, 1'b0, 16'h0099);
      wreg(A_DATA, 1'b0, 16'h00AA);
      wreg(A_DATA, 1'b0, 16'h00BB);
      wait_bit(7, 1'b1, "R6 ready after tail");
      wreg(A_CTRL, 1'b0, 16'h0000);
      wait_bit(3, 1'b0, "R10 idle after write");
      rreg(A_STAT, 1'b0, d); chk("R7 no overflow on legal writes", d, 16'h0000);
      rreg(A_ADLO, 1'b0, d); chk("R9 ptr lo after 11 bytes", d, 16'h001B);
      rreg(A_ADHI, 1'b0, d); chk("R9 ptr hi after 11 bytes", d, 16'h0020);
   endtask

   task automatic t_addr_locked();
      logic [15:0] d;
      wreg(A_CTRL, 1'b0, 16'h00C0);
      wreg(A_ADLO, 1'b0, 16'h0055);
      rreg(A_ADLO, 1'b0, d); chk("R9 address write ignored while busy", d, 16'h001B);
      wreg(A_CTRL, 1'b0, 16'h0000);
      wait_bit(3, 1'b0, "R9 idle");
   endtask

   task automatic t_read_group();
      logic [15:0] d;
      set_addr(16'h2010);
      wreg(A_CTRL, 1'b0, 16'h0080);
      wait_bit(7, 1'b1, "R3 ready when full");
      rreg(A_DATA, 1'b1, d); chk("R4 word 0", d, 16'h1122);
      rreg(A_DATA, 1'b1, d); chk("R4 word 1", d, 16'h3344);
      rreg(A_DATA, 1'b1, d); chk("R3 word 2", d, 16'h5566);
      rreg(A_DATA, 1'b1, d); chk("R3 word 3", d, 16'h7788);
      wait_bit(7, 1'b1, "R3 refill");
      rreg(A_DATA, 1'b0, d); chk("R4 byte 8", d, 16'h0099);
      rreg(A_DATA, 1'b0, d); chk("R4 byte 9", d, 16'h00AA);
      rreg(A_DATA, 1'b0, d); chk("R4 byte 10", d, 16'h00BB);
      wreg(A_CTRL, 1'b0, 16'h0000);
      rreg(A_STAT, 1'b0, d); chk("R10 read stop clears busy/ready", d & 16'h0088, 16'h0000);
   endtask

   task automatic t_underflow();
      logic [15:0] d;
      set_addr(16'h2010);
      wreg(A_CTRL, 1'b0, 16'h0080);
      rreg(A_DATA, 1'b1, d); chk("R5 early read returns 0", d, 16'h0000);
      rreg(A_STAT, 1'b0, d); chk("R5 underflow set", {15'b0, d[6]}, 16'h0001);
      wait_bit(7, 1'b1, "R5 ready");
      rreg(A_DATA, 1'b1, d); chk("R5 nothing consumed", d, 16'h1122);
      wreg(A_CTRL, 1'b0, 16'h0000);
      wreg(A_CTRL, 1'b0, 16'h0080);
      rreg(A_STAT, 1'b0, d); chk("R2 start clears underflow", {15'b0, d[6]}, 16'h0000);
      wreg(A_CTRL, 1'b0, 16'h0000);
   endtask

   task automatic t_overflow();
      logic [15:0] d;
      set_addr(16'h2100);
      wreg(A_CTRL, 1'b0, 16'h00C0);
      wait_bit(7, 1'b1, "R7 ready");
      for (int i = 0; i < 8; i++) wreg(A_DATA, 1'b1, 16'hE000 + 16'(i));
      rreg(A_STAT, 1'b0, d); chk("R7 overflow set", {15'b0, d[5]}, 16'h0001);
      wreg(A_CTRL, 1'b0, 16'h0000);
      wait_bit(3, 1'b0, "R7 idle");
      wreg(A_CTRL, 1'b0, 16'h00C0);
      rreg(A_STAT, 1'b0, d); chk("R2 start clears overflow", {15'b0, d[5]}, 16'h0000);
      wreg(A_CTRL, 1'b0, 16'h0000);
      wait_bit(3, 1'b0, "R2 idle");
   endtask

   task automatic t_wrap();
      logic [15:0] d;
      set_addr(16'h27FE);
      wreg(A_CTRL, 1'b0, 16'h00C0);
      wreg(A_DATA, 1'b1, 16'hCAFE);
      wreg(A_DATA, 1'b0, 16'h005A);
      wait_bit(7, 1'b1, "R8 drained");
      rreg(A_STAT, 1'b0, d); chk("R8 terminal count", {15'b0, d[4]}, 16'h0001);
      wreg(A_CTRL, 1'b0, 16'h0000);
      wait_bit(3, 1'b0, "R8 idle");
      rreg(A_ADLO, 1'b0, d); chk("R8 wrapped ptr lo", d, 16'h0001);
      rreg(A_ADHI, 1'b0, d); chk("R8 wrapped ptr hi", d, 16'h0020);
      set_addr(16'h27FE);
      wreg(A_CTRL, 1'b0, 16'h0080);
      wait_bit(7, 1'b1, "R8 read ready");
      rreg(A_DATA, 1'b1, d); chk("R8 last two bytes", d, 16'hCAFE);
      rreg(A_DATA, 1'b0, d); chk("R8 byte at base", d, 16'h005A);
      wreg(A_CTRL, 1'b0, 16'h0000);
   endtask

   task automatic t_alias();
      logic [15:0] d;
      set_addr(16'h2805);
      wreg(A_CTRL, 1'b0, 16'h00C0);
      wreg(A_DATA, 1'b0, 16'h003C);
      wait_bit(7, 1'b1, "R11 drained");
      wreg(A_CTRL, 1'b0, 16'h0000);
      wait_bit(3, 1'b0, "R11 idle");
      set_addr(16'h2005);
      wreg(A_CTRL, 1'b0, 16'h0080);
      wait_bit(7, 1'b1, "R11 ready");
      rreg(A_DATA, 1'b0, d); chk("R11 alias byte", d, 16'h003C);
      wreg(A_CTRL, 1'b0, 16'h0000);
   endtask

   task automatic t_stop_drain();
      logic [15:0] d;
      set_addr(16'h2200);
      wreg(A_CTRL, 1'b0, 16'h00C0);
      wait_bit(7, 1'b1, "R10 ready");
      wreg(A_DATA, 1'b1, 16'hA1A2);
      wreg(A_DATA, 1'b1, 16'hB1B2);
      wreg(A_DATA, 1'b1, 16'hC1C2);
      wreg(A_DATA, 1'b1, 16'hD1D2);
      wreg(A_CTRL, 1'b0, 16'h0000);
      rreg(A_STAT, 1'b0, d); chk("R10 busy while draining", {15'b0, d[3]}, 16'h0001);
      wait_bit(3, 1'b0, "R10 drain completes");
      set_addr(16'h2200);
      wreg(A_CTRL, 1'b0, 16'h0080);
      wait_bit(7, 1'b1, "R10 read ready");
      rreg(A_DATA, 1'b1, d); chk("R2 latched dir word 0", d, 16'hA1A2);
      rreg(A_DATA, 1'b1, d); chk("R10 word 1", d, 16'hB1B2);
      rreg(A_DATA, 1'b1, d); chk("R10 word 2", d, 16'hC1C2);
      rreg(A_DATA, 1'b1, d); chk("R10 word 3", d, 16'hD1D2);
      wreg(A_CTRL, 1'b0, 16'h0000);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_write_group();
      t_addr_locked();
      t_read_group();
      t_underflow();
      t_overflow();
      t_wrap();
      t_alias();
      t_stop_drain();
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
   end

   initial begin
      repeat (50000) @(posedge clk);
      if (!done) begin
         n_checks++;
         n_errors++;
         $display("FAIL watchdog: actual hung expected done");
         $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
         $finish;
      end
   end
endmodule